// File: doc/BRIEF.md
# Supervisor Address Segment Classifier

This block forms an effective virtual address by adding a sign-extended 16-bit offset to a 64-bit base register. It then places that address in the supervisor-level memory map. Three status inputs (a two-bit privilege level, an exception-level bit and an error-level bit) decide whether the request runs at supervisor privilege. A fourth status input selects between narrow (32-bit) and wide (64-bit) addressing.

In narrow mode the low 32 bits of the sum are sign-extended to 64 bits before they are decoded. The block also reports a two's-complement overflow of the 32-bit addition. In that case the classified result is still presented, but it must be treated as undefined.

Each valid request produces one registered result one clock later. The result carries the final address, a segment code, a translation-required flag, an address-error flag, the overflow flag and a not-supervisor flag.

Top module: `sup_seg_check`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. A synchronous active-high `rst` clears `out_valid`.
- R2: In wide mode (`in_wide`=1), `out_addr` equals `in_base` plus `in_offset` sign-extended to 64 bits, modulo 2^64.
- R3: Supervisor privilege holds only when `in_priv`=2'b01, `in_exc`=0 and `in_err`=0. Otherwise `out_notsup`=1, `out_seg`=0, `out_mapped`=0 and `out_aerr`=0.
- R4: In narrow mode (`in_wide`=0), `out_addr[31:0]` is the low 32 bits of the sum, and bits 63..32 all repeat bit 31.
- R5: In narrow mode, an address whose low word lies in 0000_0000..7FFF_FFFF gets segment code 1 (low region, 2 GB).
- R6: In narrow mode, an address whose low word lies in C000_0000..DFFF_FFFF gets code 2 (supervisor window, 0.5 GB). Low words in 8000_0000..BFFF_FFFF and in E000_0000..FFFF_FFFF get code 0 with `out_aerr`=1.
- R7: In wide mode, 0..0000_00FF_FFFF_FFFF gets code 3. 4000_0000_0000_0000..4000_00FF_FFFF_FFFF gets code 4.
- R8: In wide mode, FFFF_FFFF_C000_0000..FFFF_FFFF_DFFF_FFFF gets code 5. Every other wide address gets code 0 with `out_aerr`=1.
- R9: `out_ovf`=1 only in narrow mode, and only when both of the following hold: offset bit 15 equals base bit 31, and sum bit 31 differs from them. The privilege level does not affect it. The segment decode is still presented when `out_ovf`=1.
- R10: At supervisor privilege, `out_mapped`=1 exactly when `out_seg` is nonzero, and `out_aerr`=1 exactly when `out_seg` is 0. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request qualifier |
| in_base | input | 64 | Base register value |
| in_offset | input | 16 | Signed displacement |
| in_priv | input | 2 | Privilege level field (01 = supervisor) |
| in_exc | input | 1 | Exception-level status bit |
| in_err | input | 1 | Error-level status bit |
| in_wide | input | 1 | 1 = 64-bit addressing, 0 = 32-bit addressing |
| out_valid | output | 1 | Result qualifier, one cycle after the request |
| out_addr | output | 64 | Effective address (sign-extended in narrow mode) |
| out_seg | output | 3 | Segment code 0..5 |
| out_mapped | output | 1 | Address needs translation |
| out_aerr | output | 1 | Address error |
| out_ovf | output | 1 | Narrow-mode overflow; the result is undefined |
| out_notsup | output | 1 | Request is not at supervisor privilege |

## Verification
Two functions can fire in the same cycle: overflow detection and segment classification. A narrow-mode base close to the 7FFF_FFFF or 8000_0000 boundary, given an offset that carries across bit 31, makes both apply to one request. One such request lands in an error range and another lands in the low region. The bench checks that the segment code and error flag match the wrapped, sign-extended address, and that `out_ovf` is also set. An overflowing request at non-supervisor privilege tests the other pairing: the overflow must still be reported while the decode is suppressed.

// File: rtl/sup_seg_pkg.sv
package sup_seg_pkg;
   typedef enum logic [2:0] {
      SEG_NONE  = 3'd0,
      SEG_LOW32 = 3'd1,
      SEG_SUP32 = 3'd2,
      SEG_LOW64 = 3'd3,
      SEG_SUP64 = 3'd4,
      SEG_CMP64 = 3'd5
   } seg_e;
endpackage

// File: rtl/sup_addr_gen.sv
module sup_addr_gen #(
   parameter int ADDR_W = 64,
   parameter int OFF_W  = 16,
   parameter int HALF_W = 32
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [OFF_W-1:0]  offset,
   input  logic              wide,
   output logic [ADDR_W-1:0] addr,
   output logic              ovf
);
   localparam int EXT_W = ADDR_W - OFF_W;

   if (OFF_W >= HALF_W) begin : g_bad_off
      $error("sup_addr_gen: OFF_W must be below HALF_W");
   end
   if (ADDR_W != 2 * HALF_W) begin : g_bad_half
      $error("sup_addr_gen: ADDR_W must be twice HALF_W");
   end

   logic [ADDR_W-1:0] off_ext;
   logic [ADDR_W-1:0] sum;
   logic              sum_msb, base_msb, off_msb;

   assign off_ext  = {{EXT_W{offset[OFF_W-1]}}, offset};
   assign sum      = base + off_ext;
   assign sum_msb  = sum[HALF_W-1];
   assign base_msb = base[HALF_W-1];
   assign off_msb  = offset[OFF_W-1];

   always_comb begin
      if (wide) begin
         addr = sum;
         ovf  = 1'b0;
      end else begin
         addr = {{HALF_W{sum_msb}}, sum[HALF_W-1:0]};
         ovf  = (off_msb == base_msb) && (sum_msb != base_msb);
      end
   end

   // R4
   narrow_sext_chk: assert final (wide || (addr[ADDR_W-1:HALF_W] == {HALF_W{addr[HALF_W-1]}}))
      else $error("narrow address not sign-extended");
endmodule

// File: rtl/sup_priv_decode.sv
module sup_priv_decode #(
   parameter int PRIV_W = 2,
   parameter logic [PRIV_W-1:0] SUP_CODE = 2'b01
) (
   input  logic [PRIV_W-1:0] priv,
   input  logic              exc,
   input  logic              err,
   output logic              is_sup
);
   if (PRIV_W < 1) begin : g_bad_priv
      $error("sup_priv_decode: PRIV_W must be positive");
   end

   assign is_sup = (priv == SUP_CODE) && !exc && !err;
endmodule

// File: rtl/sup_seg_map.sv
module sup_seg_map
   import sup_seg_pkg::*;
#(
   parameter int ADDR_W  = 64,
   parameter int HALF_W  = 32,
   parameter int SPACE_W = 40
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wide,
   input  logic              is_sup,
   output seg_e              seg,
   output logic              mapped,
   output logic              aerr
);
   localparam int HI_W = ADDR_W - SPACE_W;
   localparam logic [HI_W-1:0] SUP64_TAG = {2'b01, {(HI_W-2){1'b0}}};

   if (SPACE_W >= ADDR_W - 2 || SPACE_W <= HALF_W) begin : g_bad_space
      $error("sup_seg_map: SPACE_W out of range");
   end

   logic [2:0]        top3;
   logic [HI_W-1:0]   hi_part;
   logic              upper_ones;
   seg_e              raw;

   assign top3       = addr[HALF_W-1:HALF_W-3];
   assign hi_part    = addr[ADDR_W-1:SPACE_W];
   assign upper_ones = &addr[ADDR_W-1:HALF_W];

   always_comb begin
      raw = SEG_NONE;
      if (!wide) begin
         if (!top3[2])              raw = SEG_LOW32;
         else if (top3 == 3'b110)   raw = SEG_SUP32;
      end else begin
         if (hi_part == '0)                       raw = SEG_LOW64;
         else if (hi_part == SUP64_TAG)           raw = SEG_SUP64;
         else if (upper_ones && top3 == 3'b110)   raw = SEG_CMP64;
      end
   end

   assign seg    = is_sup ? raw : SEG_NONE;
   assign mapped = is_sup && (raw != SEG_NONE);
   assign aerr   = is_sup && (raw == SEG_NONE);

   // R10
   map_err_excl_chk: assert final (!(mapped && aerr))
      else $error("mapped and error both set");
   // R6
   narrow_code_chk: assert final (wide || seg == SEG_NONE || seg == SEG_LOW32 || seg == SEG_SUP32)
      else $error("wide code in narrow mode");
endmodule

// File: rtl/sup_seg_check.sv
module sup_seg_check
   import sup_seg_pkg::*;
#(
   parameter int ADDR_W  = 64,
   parameter int OFF_W   = 16,
   parameter int HALF_W  = 32,
   parameter int SPACE_W = 40,
   parameter int PRIV_W  = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [63:0]       in_base,
   input  logic [15:0]       in_offset,
   input  logic [1:0]        in_priv,
   input  logic              in_exc,
   input  logic              in_err,
   input  logic              in_wide,
   output logic              out_valid,
   output logic [63:0]       out_addr,
   output logic [2:0]        out_seg,
   output logic              out_mapped,
   output logic              out_aerr,
   output logic              out_ovf,
   output logic              out_notsup
);
   if (ADDR_W != 64 || OFF_W != 16 || PRIV_W != 2) begin : g_bad_ports
      $error("sup_seg_check: port widths are fixed at 64/16/2");
   end

   logic [ADDR_W-1:0] c_addr;
   logic              c_ovf, c_sup, c_mapped, c_aerr;
   seg_e              c_seg;

   sup_priv_decode #(.PRIV_W(PRIV_W), .SUP_CODE(2'b01)) u_priv (
      .priv(in_priv), .exc(in_exc), .err(in_err), .is_sup(c_sup)
   );

   sup_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .HALF_W(HALF_W)) u_agen (
      .base(in_base), .offset(in_offset), .wide(in_wide),
      .addr(c_addr), .ovf(c_ovf)
   );

   sup_seg_map #(.ADDR_W(ADDR_W), .HALF_W(HALF_W), .SPACE_W(SPACE_W)) u_map (
      .addr(c_addr), .wide(in_wide), .is_sup(c_sup),
      .seg(c_seg), .mapped(c_mapped), .aerr(c_aerr)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid  <= 1'b0;
         out_addr   <= '0;
         out_seg    <= '0;
         out_mapped <= 1'b0;
         out_aerr   <= 1'b0;
         out_ovf    <= 1'b0;
         out_notsup <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_addr   <= c_addr;
            out_seg    <= c_seg;
            out_mapped <= c_mapped;
            out_aerr   <= c_aerr;
            out_ovf    <= c_ovf;
            out_notsup <= !c_sup;
         end
      end
   end

   // R1
   valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   // R1
   valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
   // R3
   notsup_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_notsup) |-> (out_seg == 3'd0 && !out_mapped && !out_aerr));
   // R9
   wide_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_wide) |=> !out_ovf);
   // R10
   sup_outcome_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_notsup) |-> $countones({out_mapped, out_aerr}) == 1);
endmodule

// File: tb/sup_seg_check_test.sv
module sup_seg_check_test;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      string       tag;
      logic [63:0] addr;
      logic [2:0]  seg;
      logic        mapped, aerr, ovf, notsup;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [63:0] in_base;
   logic [15:0] in_offset;
   logic [1:0]  in_priv;
   logic        in_exc, in_err, in_wide;
   logic        out_valid;
   logic [63:0] out_addr;
   logic [2:0]  out_seg;
   logic        out_mapped, out_aerr, out_ovf, out_notsup;

   int   n_checks = 0;
   int   n_fail   = 0;
   bit   done     = 1'b0;
   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   sup_seg_check uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_base(in_base),
      .in_offset(in_offset), .in_priv(in_priv), .in_exc(in_exc),
      .in_err(in_err), .in_wide(in_wide), .out_valid(out_valid),
      .out_addr(out_addr), .out_seg(out_seg), .out_mapped(out_mapped),
      .out_aerr(out_aerr), .out_ovf(out_ovf), .out_notsup(out_notsup)
   );

   task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic exp_t model(string tag, logic [63:0] b, logic [15:0] o,
                                  logic [1:0] p, logic x, logic e, logic w);
      exp_t r;
      logic [63:0] s, a;
      logic        sup;
      s = b + {{48{o[15]}}, o};
      a = w ? s : {{32{s[31]}}, s[31:0]};
      sup = (p == 2'b01) && !x && !e;
      r.tag  = tag;
      r.addr = a;
      r.seg  = 3'd0;
      if (!w) begin
         if (a[31:0] <= 32'h7FFF_FFFF) r.seg = 3'd1;
         else if (a[31:0] >= 32'hC000_0000 && a[31:0] <= 32'hDFFF_FFFF) r.seg = 3'd2;
      end else begin
         if (a <= 64'h0000_00FF_FFFF_FFFF) r.seg = 3'd3;
         else if (a >= 64'h4000_0000_0000_0000 && a <= 64'h4000_00FF_FFFF_FFFF) r.seg = 3'd4;
         else if (a >= 64'hFFFF_FFFF_C000_0000 && a <= 64'hFFFF_FFFF_DFFF_FFFF) r.seg = 3'd5;
      end
      r.ovf    = !w && ((!o[15] && !b[31] && s[31]) || (o[15] && b[31] && !s[31]));
      r.notsup = !sup;
      if (!sup) r.seg = 3'd0;
      r.mapped = sup && r.seg != 3'd0;
      r.aerr   = sup && r.seg == 3'd0;
      return r;
   endfunction

   task automatic drive(string tag, logic [63:0] b, logic [15:0] o, logic w,
                        logic [1:0] p = 2'b01, logic x = 1'b0, logic e = 1'b0);
      @(negedge clk);
      in_valid = 1'b1; in_base = b; in_offset = o; in_wide = w;
      in_priv = p; in_exc = x; in_err = e;
      sb.push_back(model(tag, b, o, p, x, e, w));
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // monitor: results appear at the negedge after the capturing posedge
   always @(negedge clk) begin
      if (!rst && out_valid) begin
         exp_t e;
         if (sb.size() == 0) begin
            check("R1", "unexpected out_valid", 64'd1, 64'd0);
         end else begin
            e = sb.pop_front();
            check(e.tag, "addr",   out_addr,   e.addr);
            check(e.tag, "seg",    {61'd0, out_seg}, {61'd0, e.seg});
            check(e.tag, "mapped", {63'd0, out_mapped}, {63'd0, e.mapped});
            check(e.tag, "aerr",   {63'd0, out_aerr},   {63'd0, e.aerr});
            check(e.tag, "ovf",    {63'd0, out_ovf},    {63'd0, e.ovf});
            check(e.tag, "notsup", {63'd0, out_notsup}, {63'd0, e.notsup});
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; in_valid = 1'b1; in_base = '0; in_offset = '0;
      in_priv = 2'b01; in_exc = 1'b0; in_err = 1'b0; in_wide = 1'b0;
      repeat (3) @(negedge clk);
      check("R1", "valid in reset", {63'd0, out_valid}, 64'd0);
      in_valid = 1'b0;
      rst = 1'b0;
      @(negedge clk);
      check("R1", "valid idle", {63'd0, out_valid}, 64'd0);

      // R2 wide sum with negative offset, R7 low wide region
      drive("R2_R7", 64'h0000_0012_3456_0000, 16'hFFF0, 1'b1);
      drive("R7",    64'h0000_00FF_FFFF_FFFF, 16'h0000, 1'b1);
      drive("R7",    64'h0000_00FF_FFFF_FFF0, 16'h0010, 1'b1);
      drive("R7",    64'h4000_0000_0000_0000, 16'h0000, 1'b1);
      drive("R7",    64'h4000_00FF_FFFF_FF00, 16'h00FF, 1'b1);
      drive("R7",    64'h4000_0100_0000_0000, 16'h0000, 1'b1);
      drive("R7",    64'h3FFF_FFFF_FFFF_FFFF, 16'h0000, 1'b1);
      // R8 compat window and wide errors
      drive("R8",    64'hFFFF_FFFF_C000_0000, 16'h0000, 1'b1);
      drive("R8",    64'hFFFF_FFFF_DFFF_FFFF, 16'h0000, 1'b1);
      drive("R8",    64'hFFFF_FFFF_E000_0000, 16'h0000, 1'b1);
      drive("R8",    64'hFFFF_FFFF_BFFF_FFFF, 16'h0000, 1'b1);
      drive("R8",    64'h8000_0000_0000_0000, 16'h0000, 1'b1);
      idle();
      // R4 R5 R6 narrow map, upper base bits ignored
      drive("R4_R5", 64'h1234_5678_0000_1000, 16'h0010, 1'b0);
      drive("R5",    64'h0000_0000_7FFF_FFFF, 16'h0000, 1'b0);
      drive("R6",    64'h0000_0000_8000_0000, 16'h0000, 1'b0);
      drive("R6",    64'hFFFF_FFFF_BFFF_FFFF, 16'h0000, 1'b0);
      drive("R4_R6", 64'h0000_0000_C000_0000, 16'h0000, 1'b0);
      drive("R6",    64'h0000_0000_DFFF_FFFF, 16'h0000, 1'b0);
      drive("R6",    64'h0000_0000_E000_0000, 16'h0000, 1'b0);
      // R9 overflow together with decode
      drive("R9",    64'h0000_0000_7FFF_FFF0, 16'h0020, 1'b0);
      drive("R9",    64'hFFFF_FFFF_8000_0000, 16'h8000, 1'b0);
      drive("R9",    64'hFFFF_FFFF_8000_0000, 16'h8000, 1'b1);
      drive("R9",    64'h0000_0000_7FFF_FFF0, 16'h000F, 1'b0);
      drive("R9",    64'h0000_0000_7FFF_FFF0, 16'h0020, 1'b0, 2'b00);
      // R3 privilege combinations
      drive("R3",    64'h0000_0000_0000_1000, 16'h0000, 1'b0, 2'b00);
      drive("R3",    64'h0000_0000_0000_1000, 16'h0000, 1'b0, 2'b10);
      drive("R3",    64'h0000_0000_8000_0000, 16'h0000, 1'b0, 2'b11);
      drive("R3",    64'h0000_0000_0000_1000, 16'h0000, 1'b0, 2'b01, 1'b1);
      drive("R3",    64'h0000_0000_0000_1000, 16'h0000, 1'b1, 2'b01, 1'b0, 1'b1);
      drive("R10",   64'h0000_0000_C000_0010, 16'hFFF0, 1'b0);
      idle();
      idle();
      check("R1", "valid after stream", {63'd0, out_valid}, 64'd0);
      check("R1", "results outstanding", 64'(sb.size()), 64'd0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule